// File: doc/BRIEF.md
# ADC Conversion Controller with Register Interface

This block is the digital side of a five-input, 12-bit successive-approximation converter, mapped into a byte-wide register space. Software writes a control register to pick the input channel and the analog/digital configuration of the shared port pins. It then pulses a start bit high and back low. The rising write raises a busy flag in the control register. The falling write launches the conversion.

The block then resolves one result bit per conversion-clock period, beginning with the most significant bit. For each bit it drives a trial code to an external DAC and reads back a single comparator decision. The conversion clock is derived from the system clock by a divider that a clock-setting register selects. When the last bit is decided, the block stores the code left-justified in two read-only result bytes, clears the busy flag and, if the interrupt is enabled, emits a one-cycle interrupt request.

Reads are combinational from the address bus. Writes take effect at the clock edge on which the write strobe is sampled.

Top module: `adc_ctrl_regs`

## Requirements
- R1: After reset, all four registers read 0x00, irq_o is low, and ch_sel_o and port_cfg_o are 0.
- R2: Writing address 0x22 stores bits 2:0 as the channel number and bits 5:3 as the pin configuration. These drive ch_sel_o and port_cfg_o and read back in place. Bit 6 of the written data has no effect on the stored flag.
- R3: A write to 0x22 that moves bit 7 (start) from 0 to 1 sets bit 6 (busy) of 0x22, readable in the next cycle. No conversion begins on that write.
- R4: A write to 0x22 that moves start from 1 to 0 begins a conversion. Busy clears exactly 12×D clock cycles after that write's edge, where D is the selected divisor.
- R5: Bits 1:0 of register 0x23 select D: 00 gives 2, 01 gives 8, 10 gives 32, and 11 also gives 32.
- R6: Register 0x23 reads bits 6:2 as 0. Bit 7 is stored and read back but does not change conversion timing.
- R7: Bits are decided from bit 11 down to bit 0, one per conversion-clock period. The first trial code is 0x800. A bit is kept when cmp_i is 1 and cleared otherwise, so with an ideal comparator the result equals the input code.
- R8: The result is left-justified. Address 0x21 returns result bits 11:4. Address 0x20 returns result bits 3:0 in its upper nibble, with 0 in its lower nibble.
- R9: The result bytes keep their previous value during a conversion and change on the same edge on which busy clears.
- R10: On completion, irq_o is high for exactly one cycle if irq_en_i was high, and stays low otherwise.
- R11: Writes to 0x20 and 0x21 have no effect on the result bytes.
- R12: Start (bit 7 of 0x22) reads back as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 8 | Register address for reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the trial code |
| dac_o | output | 12 | Trial code to the DAC |
| ch_sel_o | output | 3 | Selected analog channel |
| port_cfg_o | output | 3 | Pin configuration field |
| irq_en_i | input | 1 | Interrupt enable |
| irq_o | output | 1 | Conversion-complete interrupt pulse |

## Verification
A divider that loads the wrong count, or a counter not cleared at launch, shifts the busy-clear edge away from 12×D cycles. The bench checks that edge to the exact cycle for every divisor setting. A bit index or trial register that goes wrong shows up as a result byte differing from the modelled input code, and this appears on the first conversion after the fault. A result register that updates early is caught by a read of the high byte taken during the conversion. A stuck or stretched interrupt is caught one cycle after completion.

// File: rtl/adc_regs_pkg.sv
package adc_regs_pkg;
  localparam logic [7:0] ADDR_RES_LO = 8'h20;
  localparam logic [7:0] ADDR_RES_HI = 8'h21;
  localparam logic [7:0] ADDR_CTRL   = 8'h22;
  localparam logic [7:0] ADDR_CLK    = 8'h23;

  typedef enum logic [1:0] {
    CS_DIV2  = 2'b00,
    CS_DIV8  = 2'b01,
    CS_DIV32 = 2'b10,
    CS_RSVD  = 2'b11
  } clk_sel_e;

  // reserved code falls back to the slowest clock
  function automatic int unsigned div_of(clk_sel_e sel);
    case (sel)
      CS_DIV2: return 2;
      CS_DIV8: return 8;
      default: return 32;
    endcase
  endfunction
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div
  import adc_regs_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clear_i,
  input  logic     run_i,
  input  clk_sel_e sel_i,
  output logic     tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb begin
    lim    = CNT_W'(div_of(sel_i) - 1);
    tick_o = run_i && !clear_i && (cnt_q == lim);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clear_i || !run_i)    cnt_q <= '0;
    else if (cnt_q == lim)         cnt_q <= '0;
    else                           cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/adc_sar.sv
module adc_sar #(
  parameter int RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic [RES_W-1:0] trial_o,
  output logic             done_o,
  output logic [RES_W-1:0] code_o
);
  localparam int IDX_W = $clog2(RES_W);
  localparam logic [RES_W-1:0] MSB_CODE = RES_W'(1) << (RES_W - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [RES_W-1:0] trial_q;
  logic [RES_W-1:0] decided;
  logic [RES_W-1:0] next_bit;

  always_comb begin
    decided = trial_q;
    if (!cmp_i) decided[idx_q] = 1'b0;
    next_bit = RES_W'(1) << (idx_q - IDX_W'(1));
    done_o   = busy_q && tick_i && (idx_q == '0) && !start_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      trial_q <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      idx_q   <= IDX_W'(RES_W - 1);
      trial_q <= MSB_CODE;
    end else if (busy_q && tick_i) begin
      if (idx_q == '0) begin
        busy_q  <= 1'b0;
        trial_q <= decided;
      end else begin
        trial_q <= decided | next_bit;
        idx_q   <= idx_q - IDX_W'(1);
      end
    end
  end

  assign busy_o  = busy_q;
  assign trial_o = trial_q;
  assign code_o  = decided;
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
  import adc_regs_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       addr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  input  logic             cmp_i,
  output logic [RES_W-1:0] dac_o,
  output logic [2:0]       ch_sel_o,
  output logic [2:0]       port_cfg_o,
  input  logic             irq_en_i,
  output logic             irq_o
);
  localparam int LO_BITS = RES_W - 8;

  logic [2:0]       ch_q, cfg_q;
  logic             start_q, eoc_q, test_q, irq_q;
  clk_sel_e         clk_sel_q;
  logic [RES_W-1:0] res_q;

  logic wr_ctrl, wr_clk, start_rise, start_fall;
  logic tick, sar_busy, sar_done;
  logic [RES_W-1:0] sar_code;
  logic [7:0] lo_byte;

  always_comb begin
    wr_ctrl    = wr_en_i && (addr_i == ADDR_CTRL);
    wr_clk     = wr_en_i && (addr_i == ADDR_CLK);
    start_rise = wr_ctrl &&  wdata_i[7] && !start_q;
    start_fall = wr_ctrl && !wdata_i[7] &&  start_q;
  end

  adc_clk_div #(.CNT_W(CNT_W)) i_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start_fall),
    .run_i   (sar_busy),
    .sel_i   (clk_sel_q),
    .tick_o  (tick)
  );

  adc_sar #(.RES_W(RES_W)) i_sar (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_fall),
    .tick_i  (tick),
    .cmp_i   (cmp_i),
    .busy_o  (sar_busy),
    .trial_o (dac_o),
    .done_o  (sar_done),
    .code_o  (sar_code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_q      <= '0;
      cfg_q     <= '0;
      start_q   <= 1'b0;
      eoc_q     <= 1'b0;
      clk_sel_q <= CS_DIV2;
      test_q    <= 1'b0;
      res_q     <= '0;
      irq_q     <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ch_q    <= wdata_i[2:0];
        cfg_q   <= wdata_i[5:3];
        start_q <= wdata_i[7];
      end
      if (wr_clk) begin
        clk_sel_q <= clk_sel_e'(wdata_i[1:0]);
        test_q    <= wdata_i[7];
      end
      if (start_rise)    eoc_q <= 1'b1;
      else if (sar_done) eoc_q <= 1'b0;
      if (sar_done) res_q <= sar_code;
      irq_q <= sar_done && irq_en_i;
    end
  end

  always_comb begin
    lo_byte = '0;
    lo_byte[7 -: LO_BITS] = res_q[LO_BITS-1:0];
    case (addr_i)
      ADDR_RES_LO: rdata_o = lo_byte;
      ADDR_RES_HI: rdata_o = res_q[RES_W-1 -: 8];
      ADDR_CTRL:   rdata_o = {start_q, eoc_q, cfg_q, ch_q};
      ADDR_CLK:    rdata_o = {test_q, 5'b0, clk_sel_q};
      default:     rdata_o = '0;
    endcase
  end

  assign ch_sel_o   = ch_q;
  assign port_cfg_o = cfg_q;
  assign irq_o      = irq_q;
endmodule

// File: rtl/adc_ctrl_regs_chk.sv
module adc_ctrl_regs_chk #(
  parameter int RES_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       addr_i,
  input logic [7:0]       rdata_o,
  input logic [RES_W-1:0] dac_o,
  input logic             irq_o,
  input logic             sar_busy,
  input logic [RES_W-1:0] res_q
);
  p_irq_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_irq_after_conv_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(sar_busy));

  p_res_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(res_q) |-> $fell(sar_busy));

  p_msb_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sar_busy) |-> (dac_o == (RES_W'(1) << (RES_W - 1))));

  p_clk_unused_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 8'h23) |-> (rdata_o[6:2] == 5'b0));
endmodule

bind adc_ctrl_regs adc_ctrl_regs_chk #(.RES_W(RES_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .dac_o    (dac_o),
  .irq_o    (irq_o),
  .sar_busy (sar_busy),
  .res_q    (res_q)
);

// File: tb/test_adc_ctrl_regs.sv
module test_adc_ctrl_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = 8'h00;
  logic [7:0]  wdata_i = 8'h00;
  logic [7:0]  rdata_o;
  logic        cmp_i;
  logic [11:0] dac_o;
  logic [2:0]  ch_sel_o, port_cfg_o;
  logic        irq_en_i = 1'b0;
  logic        irq_o;
  logic [11:0] vin [5];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // ideal comparator model
  always_comb begin
    if (ch_sel_o < 3'd5) cmp_i = (vin[ch_sel_o] >= dac_o);
    else                 cmp_i = 1'b0;
  end

  adc_ctrl_regs i_adc_ctrl_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cmp_i(cmp_i), .dac_o(dac_o),
    .ch_sel_o(ch_sel_o), .port_cfg_o(port_cfg_o), .irq_en_i(irq_en_i),
    .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk_i);
    #1 wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  function automatic logic [11:0] code_for(int k);
    case (k)
      0: return 12'h000;
      1: return 12'hFFF;
      2: return 12'h800;
      3: return 12'h7FF;
      default: return 12'((k * 1237 + 5) % 4096);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [11:0] prev_res;
    int k;
    for (int c = 0; c < 5; c++) vin[c] = 12'h000;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    rd(8'h20, d); check("R1 lo", d, 8'h00);
    rd(8'h21, d); check("R1 hi", d, 8'h00);
    rd(8'h22, d); check("R1 ctrl", d, 8'h00);
    rd(8'h23, d); check("R1 clk", d, 8'h00);
    check("R1 irq", irq_o, 1'b0);
    check("R1 ch/cfg", {ch_sel_o, port_cfg_o}, 6'd0);

    // R2 fields and busy bit not writable
    wr(8'h22, 8'h6C);
    rd(8'h22, d); check("R2 readback busy ignored", d, 8'h2C);
    check("R2 ch_sel_o", ch_sel_o, 3'd4);
    check("R2 port_cfg_o", port_cfg_o, 3'd5);

    // R6 clock register layout
    wr(8'h23, 8'hFF);
    rd(8'h23, d); check("R6 unused zero, test kept", d, 8'h83);

    prev_res = 12'h000;
    k = 0;
    for (int sel = 0; sel < 4; sel++) begin
      int dv;
      dv = (sel == 0) ? 2 : (sel == 1) ? 8 : 32;
      wr(8'h23, {sel[0], 5'b0, sel[1:0]});
      for (int ch = 0; ch < 5; ch++) begin
        logic [11:0] code;
        logic [7:0] cv;
        code = code_for(k);
        for (int c = 0; c < 5; c++) vin[c] = ~code;
        vin[ch] = code;
        irq_en_i = (k % 3) != 2;
        cv = {2'b00, 3'(ch ^ 3), 3'(ch)};
        wr(8'h22, cv | 8'h80);
        rd(8'h22, d); check("R3 busy set on rise, R12 start", d, cv | 8'hC0);
        check("R3 no launch on rise", dac_o, prev_res);
        wr(8'h22, cv);
        rd(8'h21, d); check("R9 hi held during conversion", d, prev_res[11:4]);
        repeat (12*dv - 1) @(posedge clk_i);
        rd(8'h22, d); check("R4 R5 busy until last cycle", d[6], 1'b1);
        check("R10 no early irq", irq_o, 1'b0);
        @(posedge clk_i);
        rd(8'h22, d); check("R4 R5 busy clear at 12xD", d[6], 1'b0);
        check("R10 irq on done", irq_o, irq_en_i);
        rd(8'h21, d); check("R7 R8 high byte", d, code[11:4]);
        rd(8'h20, d); check("R8 low byte", d, {code[3:0], 4'h0});
        @(posedge clk_i);
        #1 check("R10 irq one cycle", irq_o, 1'b0);
        prev_res = code;
        k++;
      end
    end

    // R11 result bytes ignore writes
    wr(8'h20, 8'hA5);
    wr(8'h21, 8'h5A);
    rd(8'h21, d); check("R11 hi write ignored", d, prev_res[11:4]);
    rd(8'h20, d); check("R11 lo write ignored", d, {prev_res[3:0], 4'h0});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule